// File: doc/BRIEF.md
# Hash-Bucket Duplicate Detector

This block finds out whether a freshly filled cache data entry holds the same bytes as an entry that is already present. A trigger names one data-array entry that has been filled but not yet analyzed. The block reads that entry, folds its 512 bits into a 16-bit hash, and splits the hash into a bucket number and a 15-bit partial tag. It then walks the nodes of that bucket. A node records a data-array index together with the partial tag of the data found there.

A full 512-bit comparison against the data array is made only for nodes whose partial tag equals the new one, so most nodes cost a single cycle. The walk ends in one of four outcomes. A merge means the new entry is a copy of an existing one, so the analyzed block's tag can be pointed at the match and its own entry freed. An insert records the new entry in a free node. A replace overwrites a node whose entry has exactly one sharer and names that entry for back-invalidation. An abort leaves everything as it was.

The surrounding cache launches the detector on a miss, so the scan is hidden behind the memory access. Remapping tags and invalidating entries are left to the caller, which acts on the reported result.

Top module: `dd_hash_detector`

## Requirements
- R1: After reset `busy_o`, `done_o` and `rd_en_o` are low and every bucket node is empty. A trigger is taken only while `busy_o` is low. `busy_o` then stays high up to and including the result cycle. A trigger raised while busy is ignored: it produces no result of its own and does not disturb the one in progress.
- R2: In the cycle after a trigger is taken, the block requests a data-array read of the trigger index (`rd_en_o` high, `rd_idx_o` equal to `trig_idx_i`). Read data is expected on `rd_data_i` one cycle after each request.
- R3: The hash is formed by five halving XOR folds of the 512-bit block, giving 16 bits. Bit i of the hash is therefore the XOR of all data bits whose position mod 16 equals i. The partial tag is hash[14:0] with hash[15] XORed into bit 0. The bucket number is the XOR of the four 4-bit nibbles of the hash.
- R4: Nodes 0 to 15 of the bucket are visited in order, one cycle each. A full compare is made only for a valid node whose partial tag matches, and it adds one cycle. Counting clock edges from the one that takes the trigger, `done_o` is high after edge 2 + (nodes visited) + (compares made).
- R5: The first node whose full data matches ends the scan with a merge (code 2'b00), and `peer_idx_o` gives that node's data index.
- R6: With no match and at least one empty node, the lowest empty node receives the trigger index and partial tag. The result is an insert (2'b01), and `node_slot_o` gives that node.
- R7: With no match and a full bucket, the lowest node whose entry has a sharer count of exactly 1 is overwritten with the new index and tag. The result is a replace (2'b10): `peer_idx_o` gives the overwritten index, which is to be back-invalidated, and `node_slot_o` gives the node.
- R8: With no match and a full bucket in which every entry has a sharer count other than 1, the result is an abort (2'b11) and no node changes.
- R9: In the result cycle `self_idx_o` equals the trigger index. `mark_o` (set the analyzed flag) is high for merge, insert and replace, and low for abort.
- R10: `done_o` is a one-cycle pulse, and the block is idle in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start detection for one entry |
| trig_idx_i | input | 16 | Data-array index of the entry to analyze |
| rd_en_o | output | 1 | Data-array read request |
| rd_idx_o | output | 16 | Data-array read index |
| rd_data_i | input | 512 | Read data, one cycle after the request |
| shr_idx_o | output | 16 | Entry whose sharer count is looked up |
| shr_cnt_i | input | 8 | Sharer count of `shr_idx_o`, same cycle |
| done_o | output | 1 | Result valid pulse |
| res_code_o | output | 2 | 00 merge, 01 insert, 10 replace, 11 abort |
| peer_idx_o | output | 16 | Merge target or replaced index |
| node_slot_o | output | 4 | Node written on insert or replace |
| self_idx_o | output | 16 | Index that was analyzed |
| mark_o | output | 1 | Set the analyzed flag of `self_idx_o` |
| busy_o | output | 1 | Detection in progress |

## Verification
The bench drives blocks whose hash is set by their low 16 bits, so the bucket and partial tag of each block are known in advance. Copies of a block show that a merge is found. Pairs that differ only in bits 44 and 300 cancel in the fold: they share a hash but not their data, and they show that a partial-tag hit costs a compare yet does not merge. Blocks that differ only in the upper bits of the fold, together with a block in the same bucket whose partial tag differs, check the tag fold and the cycle count. Filling one bucket and then varying the sharer counts drives it through abort, a repeated abort that leaves the nodes unchanged, a replace that picks the lowest distinct node, and a later merge onto the block that was just placed.

// File: rtl/dd_pkg.sv
package dd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_HASH,
    ST_SCAN,
    ST_CMP,
    ST_FIN
  } dd_state_e;

  typedef enum logic [1:0] {
    RES_MERGE   = 2'b00,
    RES_INSERT  = 2'b01,
    RES_REPLACE = 2'b10,
    RES_ABORT   = 2'b11
  } dd_res_e;

endpackage

// File: rtl/dd_rst_sync.sv
module dd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dd_xor_fold.sv
module dd_xor_fold #(
  parameter int DATA_W = 512,
  parameter int FOLDS  = 5,
  parameter int PTAG_W = 15,
  parameter int BKT_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [PTAG_W-1:0] ptag_o,
  output logic [BKT_W-1:0]  bkt_o
);

  localparam int HASH_W = DATA_W >> FOLDS;
  localparam int NSLICE = HASH_W / BKT_W;

  // Each stage halves the width: upper half XOR lower half.
  for (genvar k = 0; k < FOLDS; k++) begin : g_lvl
    localparam int IW = DATA_W >> k;
    logic [IW/2-1:0] f;
    if (k == 0) begin : g_first
      assign f = data_i[IW/2 +: IW/2] ^ data_i[0 +: IW/2];
    end else begin : g_rest
      assign f = g_lvl[k-1].f[IW/2 +: IW/2] ^ g_lvl[k-1].f[0 +: IW/2];
    end
  end

  logic [HASH_W-1:0] hash;
  assign hash = g_lvl[FOLDS-1].f;

  // Partial tag: low bits with the leftover upper bits folded back in.
  assign ptag_o = hash[PTAG_W-1:0] ^ PTAG_W'(hash[HASH_W-1:PTAG_W]);

  // Bucket: XOR of all BKT_W-wide slices of the hash.
  logic [BKT_W-1:0] acc [NSLICE];
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    if (s == 0) begin : g_s0
      assign acc[s] = hash[0 +: BKT_W];
    end else begin : g_sn
      assign acc[s] = acc[s-1] ^ hash[s*BKT_W +: BKT_W];
    end
  end
  assign bkt_o = acc[NSLICE-1];

endmodule

// File: rtl/dd_node_store.sv
module dd_node_store #(
  parameter int BUCKETS = 16,
  parameter int NODES   = 16,
  parameter int IDX_W   = 16,
  parameter int PTAG_W  = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(BUCKETS)-1:0] rd_bkt_i,
  input  logic [$clog2(NODES)-1:0]   rd_slot_i,
  output logic                       rd_vld_o,
  output logic [IDX_W-1:0]           rd_idx_o,
  output logic [PTAG_W-1:0]          rd_ptag_o,
  input  logic                       wr_en_i,
  input  logic [$clog2(BUCKETS)-1:0] wr_bkt_i,
  input  logic [$clog2(NODES)-1:0]   wr_slot_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [PTAG_W-1:0]          wr_ptag_i
);

  localparam int BKT_W  = $clog2(BUCKETS);
  localparam int SLOT_W = $clog2(NODES);
  localparam int ENT    = BUCKETS * NODES;
  localparam int ADDR_W = BKT_W + SLOT_W;

  logic              vld_q  [ENT];
  logic [IDX_W-1:0]  idx_q  [ENT];
  logic [PTAG_W-1:0] ptag_q [ENT];

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  assign rd_addr = {rd_bkt_i, rd_slot_i};
  assign wr_addr = {wr_bkt_i, wr_slot_i};

  assign rd_vld_o  = vld_q[rd_addr];
  assign rd_idx_o  = idx_q[rd_addr];
  assign rd_ptag_o = ptag_q[rd_addr];

  // Valid bits are reset; payload is written only under the write enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT; e++) vld_q[e] <= 1'b0;
    end else if (wr_en_i) begin
      vld_q[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      idx_q[wr_addr]  <= wr_idx_i;
      ptag_q[wr_addr] <= wr_ptag_i;
    end
  end

endmodule

// File: rtl/dd_scan_fsm.sv
module dd_scan_fsm
  import dd_pkg::*;
#(
  parameter int DATA_W  = 512,
  parameter int IDX_W   = 16,
  parameter int PTAG_W  = 15,
  parameter int NODES   = 16,
  parameter int BUCKETS = 16,
  parameter int CNT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_i,
  input  logic [IDX_W-1:0]           trig_idx_i,
  output logic                       rd_en_o,
  output logic [IDX_W-1:0]           rd_idx_o,
  input  logic [DATA_W-1:0]          rd_data_i,
  output logic [IDX_W-1:0]           shr_idx_o,
  input  logic [CNT_W-1:0]           shr_cnt_i,
  input  logic [PTAG_W-1:0]          h_ptag_i,
  input  logic [$clog2(BUCKETS)-1:0] h_bkt_i,
  output logic [$clog2(BUCKETS)-1:0] nd_bkt_o,
  output logic [$clog2(NODES)-1:0]   nd_slot_o,
  input  logic                       nd_vld_i,
  input  logic [IDX_W-1:0]           nd_idx_i,
  input  logic [PTAG_W-1:0]          nd_ptag_i,
  output logic                       wr_en_o,
  output logic [$clog2(NODES)-1:0]   wr_slot_o,
  output logic [IDX_W-1:0]           wr_idx_o,
  output logic [PTAG_W-1:0]          wr_ptag_o,
  output logic                       done_o,
  output logic [1:0]                 res_code_o,
  output logic [IDX_W-1:0]           peer_idx_o,
  output logic [$clog2(NODES)-1:0]   node_slot_o,
  output logic [IDX_W-1:0]           self_idx_o,
  output logic                       mark_o,
  output logic                       busy_o
);

  localparam int BKT_W  = $clog2(BUCKETS);
  localparam int SLOT_W = $clog2(NODES);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NODES - 1);
  localparam logic [CNT_W-1:0]  ONE_SHARER = CNT_W'(1);

  dd_state_e         st_q, st_d;
  logic              hit_q, hit_d;
  logic              fre_v_q, fre_v_d;
  logic              dst_v_q, dst_v_d;
  logic [IDX_W-1:0]  self_q, self_d;
  logic [BKT_W-1:0]  bkt_q, bkt_d;
  logic [PTAG_W-1:0] ptag_q, ptag_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [IDX_W-1:0]  hidx_q, hidx_d;
  logic [SLOT_W-1:0] fre_slot_q, fre_slot_d;
  logic [SLOT_W-1:0] dst_slot_q, dst_slot_d;
  logic [IDX_W-1:0]  dst_idx_q, dst_idx_d;
  logic [DATA_W-1:0] data_q;
  logic              data_ld;

  logic last, tag_hit;
  assign last    = (slot_q == LAST_SLOT);
  assign tag_hit = nd_vld_i && (nd_ptag_i == ptag_q);
  assign data_ld = (st_q == ST_HASH);

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    hit_d      = hit_q;
    fre_v_d    = fre_v_q;
    dst_v_d    = dst_v_q;
    self_d     = self_q;
    bkt_d      = bkt_q;
    ptag_d     = ptag_q;
    slot_d     = slot_q;
    hidx_d     = hidx_q;
    fre_slot_d = fre_slot_q;
    dst_slot_d = dst_slot_q;
    dst_idx_d  = dst_idx_q;
    case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          st_d   = ST_RD;
          self_d = trig_idx_i;
        end
      end
      ST_RD: st_d = ST_HASH;
      ST_HASH: begin
        bkt_d   = h_bkt_i;
        ptag_d  = h_ptag_i;
        slot_d  = '0;
        hit_d   = 1'b0;
        fre_v_d = 1'b0;
        dst_v_d = 1'b0;
        st_d    = ST_SCAN;
      end
      ST_SCAN: begin
        if (!nd_vld_i && !fre_v_q) begin
          fre_v_d    = 1'b1;
          fre_slot_d = slot_q;
        end
        if (nd_vld_i && (shr_cnt_i == ONE_SHARER) && !dst_v_q) begin
          dst_v_d    = 1'b1;
          dst_slot_d = slot_q;
          dst_idx_d  = nd_idx_i;
        end
        if (tag_hit)   st_d = ST_CMP;
        else if (last) st_d = ST_FIN;
        else           slot_d = slot_q + 1'b1;
      end
      ST_CMP: begin
        if (rd_data_i == data_q) begin
          hit_d  = 1'b1;
          hidx_d = nd_idx_i;
          st_d   = ST_FIN;
        end else if (last) begin
          st_d = ST_FIN;
        end else begin
          slot_d = slot_q + 1'b1;
          st_d   = ST_SCAN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hit_q   <= 1'b0;
      fre_v_q <= 1'b0;
      dst_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      hit_q   <= hit_d;
      fre_v_q <= fre_v_d;
      dst_v_q <= dst_v_d;
    end
  end

  // Payload registers, no reset
  always_ff @(posedge clk) begin
    self_q     <= self_d;
    bkt_q      <= bkt_d;
    ptag_q     <= ptag_d;
    slot_q     <= slot_d;
    hidx_q     <= hidx_d;
    fre_slot_q <= fre_slot_d;
    dst_slot_q <= dst_slot_d;
    dst_idx_q  <= dst_idx_d;
  end

  always_ff @(posedge clk) begin
    if (data_ld) data_q <= rd_data_i;
  end

  // Read and lookup ports
  assign rd_en_o   = (st_q == ST_RD) || ((st_q == ST_SCAN) && tag_hit);
  assign rd_idx_o  = (st_q == ST_RD) ? self_q : nd_idx_i;
  assign shr_idx_o = nd_idx_i;
  assign nd_bkt_o  = bkt_q;
  assign nd_slot_o = slot_q;

  // Outcome
  dd_res_e res;
  always_comb begin
    if (hit_q)        res = RES_MERGE;
    else if (fre_v_q) res = RES_INSERT;
    else if (dst_v_q) res = RES_REPLACE;
    else              res = RES_ABORT;
  end

  assign done_o      = (st_q == ST_FIN);
  assign busy_o      = (st_q != ST_IDLE);
  assign res_code_o  = res;
  assign peer_idx_o  = hit_q ? hidx_q : dst_idx_q;
  assign node_slot_o = fre_v_q ? fre_slot_q : dst_slot_q;
  assign self_idx_o  = self_q;
  assign mark_o      = done_o && (res != RES_ABORT);

  assign wr_en_o   = done_o && ((res == RES_INSERT) || (res == RES_REPLACE));
  assign wr_slot_o = node_slot_o;
  assign wr_idx_o  = self_q;
  assign wr_ptag_o = ptag_q;

endmodule

// File: rtl/dd_hash_detector.sv
module dd_hash_detector #(
  parameter int DATA_W  = 512,
  parameter int FOLDS   = 5,
  parameter int IDX_W   = 16,
  parameter int PTAG_W  = 15,
  parameter int NODES   = 16,
  parameter int BUCKETS = 16,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_i,
  input  logic [IDX_W-1:0]         trig_idx_i,
  output logic                     rd_en_o,
  output logic [IDX_W-1:0]         rd_idx_o,
  input  logic [DATA_W-1:0]        rd_data_i,
  output logic [IDX_W-1:0]         shr_idx_o,
  input  logic [CNT_W-1:0]         shr_cnt_i,
  output logic                     done_o,
  output logic [1:0]               res_code_o,
  output logic [IDX_W-1:0]         peer_idx_o,
  output logic [$clog2(NODES)-1:0] node_slot_o,
  output logic [IDX_W-1:0]         self_idx_o,
  output logic                     mark_o,
  output logic                     busy_o
);

  localparam int BKT_W  = $clog2(BUCKETS);
  localparam int SLOT_W = $clog2(NODES);

  logic              rst_i_n;
  logic [PTAG_W-1:0] h_ptag;
  logic [BKT_W-1:0]  h_bkt;
  logic [BKT_W-1:0]  nd_bkt;
  logic [SLOT_W-1:0] nd_slot;
  logic              nd_vld;
  logic [IDX_W-1:0]  nd_idx;
  logic [PTAG_W-1:0] nd_ptag;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [IDX_W-1:0]  wr_idx;
  logic [PTAG_W-1:0] wr_ptag;

  dd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dd_xor_fold #(
    .DATA_W (DATA_W),
    .FOLDS  (FOLDS),
    .PTAG_W (PTAG_W),
    .BKT_W  (BKT_W)
  ) u_fold (
    .data_i (rd_data_i),
    .ptag_o (h_ptag),
    .bkt_o  (h_bkt)
  );

  dd_node_store #(
    .BUCKETS (BUCKETS),
    .NODES   (NODES),
    .IDX_W   (IDX_W),
    .PTAG_W  (PTAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .rd_bkt_i  (nd_bkt),
    .rd_slot_i (nd_slot),
    .rd_vld_o  (nd_vld),
    .rd_idx_o  (nd_idx),
    .rd_ptag_o (nd_ptag),
    .wr_en_i   (wr_en),
    .wr_bkt_i  (nd_bkt),
    .wr_slot_i (wr_slot),
    .wr_idx_i  (wr_idx),
    .wr_ptag_i (wr_ptag)
  );

  dd_scan_fsm #(
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .PTAG_W  (PTAG_W),
    .NODES   (NODES),
    .BUCKETS (BUCKETS),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .trig_i      (trig_i),
    .trig_idx_i  (trig_idx_i),
    .rd_en_o     (rd_en_o),
    .rd_idx_o    (rd_idx_o),
    .rd_data_i   (rd_data_i),
    .shr_idx_o   (shr_idx_o),
    .shr_cnt_i   (shr_cnt_i),
    .h_ptag_i    (h_ptag),
    .h_bkt_i     (h_bkt),
    .nd_bkt_o    (nd_bkt),
    .nd_slot_o   (nd_slot),
    .nd_vld_i    (nd_vld),
    .nd_idx_i    (nd_idx),
    .nd_ptag_i   (nd_ptag),
    .wr_en_o     (wr_en),
    .wr_slot_o   (wr_slot),
    .wr_idx_o    (wr_idx),
    .wr_ptag_o   (wr_ptag),
    .done_o      (done_o),
    .res_code_o  (res_code_o),
    .peer_idx_o  (peer_idx_o),
    .node_slot_o (node_slot_o),
    .self_idx_o  (self_idx_o),
    .mark_o      (mark_o),
    .busy_o      (busy_o)
  );

endmodule

// File: rtl/dd_hash_detector_chk.sv
module dd_hash_detector_chk #(
  parameter int IDX_W = 16,
  parameter int NODES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic [IDX_W-1:0] trig_idx_i,
  input logic             rd_en_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             done_o,
  input logic [1:0]       res_code_o,
  input logic [IDX_W-1:0] self_idx_o,
  input logic             mark_o,
  input logic             busy_o
);

  localparam int MAX_BUSY = 2 * NODES + 3;
  localparam int BC_W     = $clog2(MAX_BUSY + 2);

  logic [BC_W-1:0]  busy_cnt;
  logic [IDX_W-1:0] cap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      cap_idx  <= '0;
    end else begin
      if (busy_o && busy_cnt <= BC_W'(MAX_BUSY)) busy_cnt <= busy_cnt + 1'b1;
      else if (!busy_o)                          busy_cnt <= '0;
      if (trig_i && !busy_o) cap_idx <= trig_idx_i;
    end
  end

  assert_accept_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !busy_o) |=> (busy_o && rd_en_o && rd_idx_o == $past(trig_idx_i)));

  assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  assert_read_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_self_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (self_idx_o == cap_idx));

  assert_mark_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mark_o |-> (done_o && res_code_o != 2'b11));

  assert_abort_unmarked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && res_code_o != 2'b11) |-> mark_o);

  assert_scan_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_cnt < BC_W'(MAX_BUSY)));

endmodule

bind dd_hash_detector dd_hash_detector_chk #(.IDX_W(IDX_W), .NODES(NODES)) u_chk (.*);

// File: tb/dd_hash_detector_tb.sv
`timescale 1ns/1ps
module dd_hash_detector_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         trig_i;
  logic [15:0]  trig_idx_i;
  logic         rd_en_o;
  logic [15:0]  rd_idx_o;
  logic [511:0] rd_data_i;
  logic [15:0]  shr_idx_o;
  logic [7:0]   shr_cnt_i;
  logic         done_o;
  logic [1:0]   res_code_o;
  logic [15:0]  peer_idx_o;
  logic [3:0]   node_slot_o;
  logic [15:0]  self_idx_o;
  logic         mark_o;
  logic         busy_o;

  always #5 clk = ~clk;

  dd_hash_detector u_dut (.*);

  // Data array and sharer-count models
  logic [511:0] mem     [64];
  logic [7:0]   cnt_mem [64];

  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_idx_o[5:0]];
  assign shr_cnt_i = cnt_mem[shr_idx_o[5:0]];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, start_cyc = 0, n_seen = 0, n_push = 0;
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference bucket table
  bit          ref_v  [16][16];
  logic [15:0] ref_ix [16][16];
  logic [14:0] ref_pt [16][16];

  typedef struct {
    logic [1:0]  res;
    logic [15:0] peer;
    logic [3:0]  slot;
    logic        mark;
    logic [15:0] self;
    int          lat;
    string       req;
  } exp_t;
  exp_t q[$];

  function automatic logic [15:0] hash16(logic [511:0] d);
    logic [15:0] h = '0;
    for (int j = 0; j < 512; j++) h[j % 16] ^= d[j];
    return h;
  endfunction

  function automatic logic [511:0] mk(logic [15:0] lo, bit twin);
    logic [511:0] d = '0;
    d[15:0] = lo;
    if (twin) begin d[44] = 1'b1; d[300] = 1'b1; end
    return d;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  // Driver: compute expectation, push, then trigger
  task automatic run(int idx, string req, bit poke_busy);
    exp_t e;
    logic [15:0] h;
    logic [14:0] pt;
    logic [3:0]  b;
    int visited = 0, cmps = 0, fs = -1, ds = -1;
    bit hit = 0;
    h  = hash16(mem[idx]);
    pt = h[14:0] ^ {14'b0, h[15]};
    b  = h[3:0] ^ h[7:4] ^ h[11:8] ^ h[15:12];
    e.peer = '0; e.slot = '0; e.self = 16'(idx); e.req = req;
    for (int s = 0; s < 16; s++) begin
      visited++;
      if (!ref_v[b][s] && fs < 0) fs = s;
      if (ref_v[b][s] && cnt_mem[ref_ix[b][s][5:0]] == 8'd1 && ds < 0) ds = s;
      if (ref_v[b][s] && ref_pt[b][s] == pt) begin
        cmps++;
        if (mem[ref_ix[b][s][5:0]] == mem[idx]) begin
          hit = 1; e.peer = ref_ix[b][s]; break;
        end
      end
    end
    if (hit) e.res = 2'b00;
    else if (fs >= 0) begin
      e.res = 2'b01; e.slot = 4'(fs);
      ref_v[b][fs] = 1; ref_ix[b][fs] = 16'(idx); ref_pt[b][fs] = pt;
    end else if (ds >= 0) begin
      e.res = 2'b10; e.slot = 4'(ds); e.peer = ref_ix[b][ds];
      ref_ix[b][ds] = 16'(idx); ref_pt[b][ds] = pt;
    end else e.res = 2'b11;
    e.mark = (e.res != 2'b11);
    e.lat  = 2 + visited + cmps;
    q.push_back(e);
    n_push++;
    @(negedge clk);
    trig_i = 1'b1; trig_idx_i = 16'(idx); start_cyc = cyc + 1;
    @(negedge clk);
    trig_i = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      trig_i = 1'b1; trig_idx_i = 16'd1;
      @(negedge clk);
      trig_i = 1'b0;
    end
    wait_idle();
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      n_seen++;
      if (q.size() == 0) chk("R1", "unexpected result", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "result code", res_code_o, e.res);
        if (e.res == 2'b00 || e.res == 2'b10) chk(e.req, "peer index", peer_idx_o, e.peer);
        if (e.res == 2'b01 || e.res == 2'b10) chk(e.req, "node slot", node_slot_o, e.slot);
        chk("R9", "mark", mark_o, e.mark);
        chk("R9", "self index", self_idx_o, e.self);
        chk("R4", "latency", cyc - start_cyc, e.lat);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: got %0h expected %0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; cnt_mem[i] = 8'd2; end
    for (int b = 0; b < 16; b++)
      for (int s = 0; s < 16; s++) ref_v[b][s] = 0;
    rd_data_i = '0;
    trig_i = 1'b0; trig_idx_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "read after reset", rd_en_o, 0);

    // Bucket 1, partial tag 1
    mem[1] = mk(16'h0001, 0);
    mem[2] = mk(16'h0001, 0);
    mem[3] = mk(16'h0001, 1);   // same hash, different data
    mem[9] = mk(16'h0001, 1);
    mem[4] = mk(16'h1110, 0);   // bucket 1, different partial tag
    run(1, "R6", 0);            // insert slot 0
    run(2, "R5", 0);            // merge onto 1, one compare
    run(3, "R4", 0);            // compare fails, insert slot 1
    run(9, "R5", 0);            // compare fails at 0, merges at 1
    run(4, "R3", 0);            // no compares, insert slot 2

    // Upper fold bits: hash 0x8000 -> bucket 8, tag 1; bit 3 -> bucket 8, tag 8
    mem[5][511] = 1'b1;
    mem[6][271] = 1'b1;
    mem[7][3]   = 1'b1;
    run(5, "R3", 0);
    run(6, "R3", 0);            // same hash, compare, insert slot 1
    run(7, "R3", 0);            // no compare
    run(8, "R3", 0);            // all-zero block, bucket 0

    // Fill bucket 1 with shared entries
    for (int k = 1; k <= 13; k++) begin
      mem[9 + k] = mk(16'(1 | (k << 4) | (k << 8)), 0);
      run(9 + k, "R6", 0);
    end
    mem[23] = mk(16'(1 | (14 << 4) | (14 << 8)), 0);
    mem[24] = mem[23];
    run(23, "R8", 0);           // full, all shared: abort
    run(24, "R8", 0);           // still abort: nothing was written
    cnt_mem[11] = 8'd1;
    run(23, "R7", 0);           // replaces idx 11 at slot 4
    mem[25] = mem[23];
    run(25, "R7", 0);           // merges onto the replacing entry
    cnt_mem[12] = 8'd1;
    cnt_mem[13] = 8'd1;
    mem[26] = mk(16'(1 | (15 << 4) | (15 << 8)), 0);
    run(26, "R7", 0);           // lowest distinct node is chosen

    // Trigger during busy is ignored
    mem[27] = mk(16'h0002, 0);
    run(27, "R1", 1);

    repeat (5) @(negedge clk);
    chk("R10", "results seen", n_seen, n_push);
    chk("R1", "idle at end", busy_o, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule